// File: doc/BRIEF.md
# CRC-8 Byte Stream Generator

This block computes an 8-bit check byte over a short payload of one to four bytes. It divides by the polynomial x^8 + x^2 + x + 1, which is the one used for ATM header error control. The host pulses a start strobe. It then presents payload bytes MSB first on a valid/ready byte interface and marks the final byte. Each accepted byte is folded into the running remainder in a single clock through eight unrolled shift/XOR stages.

After the final byte, the block pushes eight logic-one padding bits through the same stages. It then registers the remainder as the check byte and raises a one-cycle done pulse. The check byte therefore equals the remainder of the long division of the payload, followed by eight ones, by 1_0000_0111. It is not the usual zero-augmented value.

A new start strobe restarts the computation at any moment and drops any partial remainder. The block only computes; it does no framing and no comparison.

Top module: `crc8_stream`

## Requirements
- R1: `crc_o` equals the remainder of dividing the payload bits, MSB first and followed by eight one bits, by 1_0000_0111 (x^8+x^2+x+1) through repeated XOR at the leftmost one, stopped once the value is below 1_0000_0000. For a single 0x00 byte, the result is 0xFF.
- R2: Payloads of 1, 2, 3 and 4 bytes are each supported, and the length is chosen per frame by `in_last_i`.
- R3: While reset is held, and in the cycle after it, `in_ready_o` and `done_o` are 0 and `crc_o` is 0x00.
- R4: The cycle after `start_i` is sampled high, the remainder is zero and `in_ready_o` is 1.
- R5: When a byte with `in_last_i`=1 is accepted at edge k, `done_o` is 1 for exactly the cycle after edge k+1, and `crc_o` carries the new check byte from that edge onward. `crc_o` changes only at edges that raise `done_o`.
- R6: A `start_i` pulse during a frame, including the padding cycle, discards the partial remainder. No `done_o` is produced for the abandoned frame, and the next frame's result depends only on its own bytes.
- R7: A byte is accepted only when `in_valid_i` and `in_ready_o` are both 1 and `start_i` is 0. Bytes presented while idle, or while `in_valid_i` is 0, have no effect on `crc_o` or `done_o`.
- R8: The fourth accepted byte ends the frame even when `in_last_i` is 0, and further bytes before the next start are ignored.
- R9: `in_ready_o` is 0 in the padding cycle and stays 0 after `done_o` until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new frame; clears the remainder |
| in_valid_i | input | 1 | Payload byte present |
| in_data_i | input | 8 | Payload byte, MSB first |
| in_last_i | input | 1 | Marks the final payload byte |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| crc_o | output | 8 | Registered check byte |
| done_o | output | 1 | One-cycle pulse when `crc_o` is updated |

## Verification
The block becomes ready one edge after the start strobe. The result appears two edges after the edge that accepts the last byte: one edge to fold that byte, and one to fold the padding and register the result. The bench drives all inputs on the falling edge. It counts those edges exactly and samples `in_ready_o` after the start edge. It samples `done_o` low after the byte edge, high with the result after the padding edge, and low again one edge later. Expected check bytes come from a plain long-division model over the padded bit string.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
    localparam int unsigned CRC_W    = 8;
    localparam logic [7:0]  CRC_POLY = 8'h07;   // x^8 implicit, x^2+x+1 below
    localparam logic [7:0]  PAD_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PAD  = 2'd2
    } crc_state_e;

    // One bit of long division: shift the next dividend bit into the remainder,
    // subtract the polynomial when an x^8 term appears.
    function automatic logic [CRC_W-1:0] div_step(input logic [CRC_W-1:0] r, input logic b);
        return {r[CRC_W-2:0], b} ^ (r[CRC_W-1] ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/crc8_fold.sv
module crc8_fold
    import crc8_pkg::*;
(
    input  logic [CRC_W-1:0] rem_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] rem_o
);
    localparam int unsigned STAGES = 8;

    logic [CRC_W-1:0] chain [STAGES+1];

    assign chain[0] = rem_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign chain[g+1] = div_step(chain[g], byte_i[STAGES-1-g]);
    end

    assign rem_o = chain[STAGES];
endmodule

// File: rtl/crc8_ctrl.sv
module crc8_ctrl
    import crc8_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic in_valid_i,
    input  logic in_last_i,
    output logic ready_o,
    output logic accept_o,
    output logic pad_o,
    output logic done_o
);
    localparam int unsigned CW = $clog2(MAX_BYTES + 1);

    crc_state_e     state_q;
    logic [CW-1:0]  cnt_q;
    logic           done_q;
    logic           last_eff;

    assign ready_o  = (state_q == ST_RUN);
    assign accept_o = ready_o && in_valid_i && !start_i;
    assign pad_o    = (state_q == ST_PAD) && !start_i;
    assign last_eff = in_last_i || (cnt_q == CW'(MAX_BYTES - 1));
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= pad_o;
            if (start_i) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_RUN: if (accept_o) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_eff) state_q <= ST_PAD;
                    end
                    ST_PAD:  state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assert_pad_to_done_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAD && !start_i) |=> done_o);

    assert_max_len_R8: assert property (@(posedge clk) disable iff (rst)
        (accept_o && cnt_q == CW'(MAX_BYTES - 1)) |=> (state_q == ST_PAD));

    assert_ready_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ready_o);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/crc8_stream.sv
module crc8_stream
    import crc8_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic [7:0] crc_o,
    output logic       done_o
);
    logic             accept;
    logic             pad;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_next;
    logic [7:0]       fold_byte;
    logic [CRC_W-1:0] crc_q;

    crc8_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_last_i  (in_last_i),
        .ready_o    (in_ready_o),
        .accept_o   (accept),
        .pad_o      (pad),
        .done_o     (done_o)
    );

    // Padding reuses the same unrolled stages as payload bytes.
    assign fold_byte = pad ? PAD_BYTE : in_data_i;

    crc8_fold u_fold (
        .rem_i  (rem_q),
        .byte_i (fold_byte),
        .rem_o  (rem_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            crc_q <= '0;
        end else if (start_i) begin
            rem_q <= '0;
        end else if (accept) begin
            rem_q <= rem_next;
        end else if (pad) begin
            crc_q <= rem_next;
        end
    end

    assign crc_o = crc_q;

    assert_reset_quiet_R3: assert property (@(posedge clk)
        rst |=> (!done_o && !in_ready_o && crc_o == 8'h00));

    assert_crc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(crc_o));

    assert_no_ready_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !in_ready_o);

    assert_ready_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_ready_o, done_o}));
endmodule

// File: tb/test_crc8_stream.sv
module test_crc8_stream;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       in_valid_i;
    logic [7:0] in_data_i;
    logic       in_last_i;
    logic       in_ready_o;
    logic [7:0] crc_o;
    logic       done_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    crc8_stream i_crc8_stream (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .in_last_i  (in_last_i),
        .in_ready_o (in_ready_o),
        .crc_o      (crc_o),
        .done_o     (done_o)
    );

    localparam int NVEC = 10;
    localparam logic [31:0] VEC_DATA [NVEC] = '{
        32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_FFFF,
        32'hFFFF_FFFF, 32'h0000_0000, 32'h0012_3456, 32'h0000_A55A,
        32'h8000_0001, 32'h0000_0080
    };
    localparam int VEC_LEN [NVEC] = '{1, 4, 1, 2, 4, 3, 3, 2, 4, 1};
    localparam int VEC_GAP [NVEC] = '{0, 0, 1, 0, 2, 0, 1, 0, 0, 3};

    // Independent model: plain long division of payload followed by eight ones.
    function automatic logic [7:0] model(input logic [31:0] data, input int len);
        logic [39:0] v;
        int nbits;
        v     = (40'(data) << 8) | 40'hFF;
        nbits = 8 * len + 8;
        for (int i = nbits - 1; i >= 8; i--) begin
            if (v[i]) v = v ^ (40'(9'h107) << (i - 8));
        end
        return v[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives a full frame; returns the result seen with done.
    task automatic run_frame(input logic [31:0] data, input int len, input bit use_last,
                             input int gap, input string req);
        logic [7:0] exp;
        exp = model(data, len);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(in_ready_o === 1'b1, "R4 ready after start", in_ready_o, 1);
        for (int j = 0; j < len; j++) begin
            for (int g = 0; g < gap; g++) begin
                in_valid_i = 1'b0;
                in_data_i  = 8'hC3;          // junk while not valid (R7)
                @(negedge clk);
                chk(done_o === 1'b0, "R7 gap no done", done_o, 0);
            end
            in_valid_i = 1'b1;
            in_data_i  = data[8*(len-1-j) +: 8];
            in_last_i  = use_last && (j == len - 1);
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
        chk(in_ready_o === 1'b0 && done_o === 1'b0, "R9 pad cycle not ready", {in_ready_o, done_o}, 0);
        @(negedge clk);
        chk(done_o === 1'b1, {req, " done due"}, done_o, 1);
        chk(crc_o === exp, {req, " result"}, crc_o, exp);
        @(negedge clk);
        chk(done_o === 1'b0 && crc_o === exp, "R5 single pulse, held", {done_o, crc_o}, {1'b0, exp});
        chk(in_ready_o === 1'b0, "R9 idle after done", in_ready_o, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        rst = 1'b1; start_i = 1'b0; in_valid_i = 1'b0; in_data_i = 8'h00; in_last_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready_o === 0 && done_o === 0 && crc_o === 8'h00, "R3 reset state",
            {in_ready_o, done_o, crc_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready_o === 0 && done_o === 0 && crc_o === 8'h00, "R3 after reset",
            {in_ready_o, done_o, crc_o}, 0);

        // R1 known value: single zero byte gives all ones.
        chk(model(32'h0, 1) === 8'hFF, "R1 model zero byte", model(32'h0, 1), 8'hFF);

        // Vector table (R1, R2)
        for (int k = 0; k < NVEC; k++)
            run_frame(VEC_DATA[k], VEC_LEN[k], 1'b1, VEC_GAP[k], "R1 R2 table");

        // Random payloads of every length (R2)
        for (int k = 0; k < 40; k++)
            run_frame($urandom, (k % 4) + 1, 1'b1, k % 2, "R2 random");

        // R7: bytes while idle are ignored
        held = crc_o;
        in_valid_i = 1'b1; in_data_i = 8'h5A; in_last_i = 1'b1;
        repeat (3) @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        @(negedge clk);
        chk(done_o === 0 && crc_o === held && in_ready_o === 0, "R7 idle bytes ignored",
            {done_o, crc_o}, {1'b0, held});

        // R8: fourth byte ends the frame without last, extra byte ignored
        run_frame(32'hDEAD_BEEF, 4, 1'b0, 0, "R8 forced end");
        held = crc_o;
        in_valid_i = 1'b1; in_data_i = 8'h11; in_last_i = 1'b1;
        repeat (3) @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        chk(done_o === 0 && crc_o === held, "R8 fifth byte ignored", {done_o, crc_o}, {1'b0, held});

        // R6: restart mid-frame after two bytes
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        in_valid_i = 1'b1; in_data_i = 8'hFF; in_last_i = 1'b0;
        repeat (2) @(negedge clk);
        in_valid_i = 1'b0;
        run_frame(32'h0000_0042, 1, 1'b1, 0, "R6 restart mid-frame");

        // R6: restart during the padding cycle suppresses done
        held = crc_o;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        in_valid_i = 1'b1; in_data_i = 8'h99; in_last_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        start_i = 1'b1;                    // sampled at the padding edge
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o === 0 && crc_o === held, "R6 pad restart no done", {done_o, crc_o}, {1'b0, held});
        chk(in_ready_o === 1'b1, "R6 ready after restart", in_ready_o, 1);
        repeat (2) @(negedge clk);
        chk(done_o === 0 && crc_o === held, "R6 abandoned frame silent", {done_o, crc_o}, {1'b0, held});
        run_frame(32'h0000_0099, 1, 1'b1, 0, "R6 fresh frame");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule